// File: doc/BRIEF.md
# Horizontal Pixel Crop Unit

This block sits in a pixel stream between the framebuffer fetch and the compositor. Each input line carries a fixed number of pixels. The unit removes a programmable number of pixels from the left edge and from the right edge of every line, so that only the selected window goes on. The number of lines is not changed: every input line yields one output line.

Configuration comes as two 32-bit words and two control bits:
- **Size word:** source width minus one in bits 31:16 and line count minus one in bits 15:0.
- **Crop word:** the left crop amount (the window's x offset) in bits 31:16 and the right field in bits 15:0. The right field is the source width minus the sum of x offset and window width, minus one.
- **Bypass bit:** forces pass-through. It is used when the window covers the whole line, and software then writes zero into both crop amounts.
- **Reload-hold bit:** keeps the current active configuration in place.

The unit takes a new configuration only at the start of a frame. Input and output are valid/ready pixel streams with end-of-line and end-of-frame markers. The output markers are regenerated on the last kept pixel.

Top module: `hcrop_unit`

## Requirements
- R1: After a synchronous active-low reset, out_valid is low and in_ready is high.
- R2: While the active configuration has bypass set, every input pixel is forwarded unchanged and in order, with its end-of-line and end-of-frame flags copied as they arrive.
- R3: Without bypass, a pixel at column index c (0 = first pixel of the line) is forwarded only when left <= c < (size[31:16] - right). Here left is crop[31:16] and right is crop[15:0], so a right field of 0 still removes one pixel. Forwarded pixels keep their input order.
- R4: Pixels outside the window are accepted without output, and they never stall the input: with out_ready held high, in_ready stays high.
- R5: Without bypass, out_eol is set on the last forwarded pixel of each line and on no other pixel, so each output line carries exactly the window width.
- R6: Without bypass, out_eof is set only on the last forwarded pixel of line index size[15:0]. Every input line yields one output line.
- R7: The size word and crop word are sampled only when the first pixel of a frame is accepted. Changes made in the middle of a frame take effect from the next frame.
- R8: While the reload-hold input is high at a frame start, the active configuration is kept and the newly programmed words are ignored.
- R9: While out_valid is high and out_ready is low, out_valid, out_data, out_eol and out_eof hold their values.
- R10: out_eof is never set without out_eol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bypass | input | 1 | Pass-through request |
| cfg_hold | input | 1 | Reload-hold: keep the active configuration at frame start |
| cfg_size | input | 32 | {source width - 1, line count - 1} |
| cfg_crop | input | 32 | {left crop amount, right field} |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with in_valid |
| in_data | input | PIX_W | Input pixel |
| in_eol | input | 1 | Last pixel of an input line |
| in_eof | input | 1 | Last pixel of an input frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | PIX_W | Output pixel |
| out_eol | output | 1 | Last forwarded pixel of a line |
| out_eof | output | 1 | Last forwarded pixel of a frame |

## Verification
Four properties are checked on every cycle:
- outputs hold steady under backpressure;
- end-of-frame always comes with end-of-line;
- an accepted dropped pixel never produces an output;
- with reload-hold set, the active configuration stays fixed at frame start.

A per-line output counter is also compared against the active window width on every end-of-line.

Some behaviours only the bench scenarios can show, because each needs whole frames compared against a reference model:
- the exact window position from the field encoding, including the right field of zero that still drops a pixel;
- a single-pixel window;
- a crop change in the middle of a frame that takes effect only at the next frame;
- a held reload followed by its release.

// File: rtl/hcrop_pkg.sv
// Shared types for the horizontal crop unit.
// Field width is fixed by the 16-bit halves of the configuration words.
package hcrop_pkg;
    localparam int FIELD_W = 16;
    localparam int REG_W   = 2 * FIELD_W;

    typedef struct packed {
        logic               bypass;
        logic [FIELD_W-1:0] w_m1;
        logic [FIELD_W-1:0] h_m1;
        logic [FIELD_W-1:0] left;
        logic [FIELD_W-1:0] right;
    } crop_cfg_t;
endpackage

// File: rtl/hcrop_cfg_shadow.sv
// Configuration shadow: holds the configuration that governs the current
// frame. A frame starts after reset and after every accepted end-of-frame
// pixel. While at a frame start and not held, the programmed configuration
// is presented directly, so the first pixel already uses it. It is captured
// into the active register when that first pixel is accepted.
// Assumes every frame ends with an in_eof pixel.
module hcrop_cfg_shadow
    import hcrop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  crop_cfg_t prog_cfg,
    input  logic      hold,
    input  logic      in_fire,
    input  logic      in_eof,
    output crop_cfg_t eff_cfg,
    output crop_cfg_t active_cfg,
    output logic      at_start
);
    logic load_now;

    // Frame-start load decision and effective configuration mux.
    always_comb begin
        load_now = at_start && !hold;
        eff_cfg  = load_now ? prog_cfg : active_cfg;
    end

    // Frame-start flag: set by reset and by an accepted end-of-frame pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            at_start <= 1'b1;
        else if (in_fire)
            at_start <= in_eof;
    end

    // Active register: captured on the first accepted pixel of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_cfg        <= '0;
            active_cfg.bypass <= 1'b1;
        end else if (in_fire && at_start) begin
            active_cfg <= eff_cfg;
        end
    end
endmodule

// File: rtl/hcrop_line_tracker.sv
// Line tracker: counts the column and line of each input pixel and decides
// whether it lies inside the window. It also marks the last kept pixel of a
// line and of a frame. The window's upper bound (exclusive) is w_m1 - right,
// which follows from the right field being encoded as remaining pixels - 1.
// Assumes input lines are delimited by in_eol and frames by in_eof.
module hcrop_line_tracker
    import hcrop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  crop_cfg_t cfg,
    input  logic      in_fire,
    input  logic      in_eol,
    input  logic      in_eof,
    output logic      keep,
    output logic      mark_eol,
    output logic      mark_eof
);
    logic [FIELD_W-1:0] col;
    logic [FIELD_W-1:0] row;
    logic [FIELD_W-1:0] lim;
    logic               last_kept;

    // Window decision and marker regeneration for the current pixel.
    always_comb begin
        lim       = cfg.w_m1 - cfg.right;
        last_kept = (col == lim - 1'b1);
        if (cfg.bypass) begin
            keep     = 1'b1;
            mark_eol = in_eol;
            mark_eof = in_eof;
        end else begin
            keep     = (col >= cfg.left) && (col < lim);
            mark_eol = last_kept;
            mark_eof = last_kept && (row == cfg.h_m1);
        end
    end

    // Column counter: restarts after each accepted end-of-line pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col <= '0;
        else if (in_fire)
            col <= (in_eol || in_eof) ? '0 : col + 1'b1;
    end

    // Line counter: restarts after each accepted end-of-frame pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (in_fire) begin
            if (in_eof)
                row <= '0;
            else if (in_eol)
                row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/hcrop_out_stage.sv
// Output stage: one register slot for pixel, end-of-line and end-of-frame.
// Input is ready whenever the slot is empty or being drained. Dropped pixels
// are accepted through the same ready and simply not loaded.
module hcrop_out_stage #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             keep,
    input  logic [PIX_W-1:0] pix,
    input  logic             mark_eol,
    input  logic             mark_eof,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_eol,
    output logic             out_eof
);
    logic take;

    // Ready when the slot can accept; load only pixels inside the window.
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready && keep;
    end

    // Slot valid flag: filled on take, emptied on drain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (take)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    // Slot payload: captured on take, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_eol  <= 1'b0;
            out_eof  <= 1'b0;
        end else if (take) begin
            out_data <= pix;
            out_eol  <= mark_eol;
            out_eof  <= mark_eof;
        end
    end
endmodule

// File: rtl/hcrop_unit.sv
// Horizontal pixel crop unit top. Decodes the size and crop words, shadows
// them at frame start, tracks the pixel position and forwards only the
// pixels inside the window through a one-slot output register.
// Assumes the upstream line length matches the programmed source width.
module hcrop_unit
    import hcrop_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bypass,
    input  logic             cfg_hold,
    input  logic [REG_W-1:0] cfg_size,
    input  logic [REG_W-1:0] cfg_crop,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_eol,
    input  logic             in_eof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_eol,
    output logic             out_eof
);
    localparam int HI_LSB = FIELD_W;

    crop_cfg_t prog_cfg;
    crop_cfg_t eff_cfg;
    crop_cfg_t active_cfg;
    logic      at_start;
    logic      in_fire;
    logic      keep;
    logic      mark_eol;
    logic      mark_eof;

    // Field decode of the configuration words and input handshake.
    always_comb begin
        prog_cfg.bypass = cfg_bypass;
        prog_cfg.w_m1   = cfg_size[REG_W-1:HI_LSB];
        prog_cfg.h_m1   = cfg_size[HI_LSB-1:0];
        prog_cfg.left   = cfg_crop[REG_W-1:HI_LSB];
        prog_cfg.right  = cfg_crop[HI_LSB-1:0];
        in_fire         = in_valid && in_ready;
    end

    hcrop_cfg_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_cfg   (prog_cfg),
        .hold       (cfg_hold),
        .in_fire    (in_fire),
        .in_eof     (in_eof),
        .eff_cfg    (eff_cfg),
        .active_cfg (active_cfg),
        .at_start   (at_start)
    );

    hcrop_line_tracker u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (eff_cfg),
        .in_fire  (in_fire),
        .in_eol   (in_eol),
        .in_eof   (in_eof),
        .keep     (keep),
        .mark_eol (mark_eol),
        .mark_eof (mark_eof)
    );

    hcrop_out_stage #(.PIX_W(PIX_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .keep      (keep),
        .pix       (in_data),
        .mark_eol  (mark_eol),
        .mark_eof  (mark_eof),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_eol   (out_eol),
        .out_eof   (out_eof)
    );
endmodule

// File: rtl/hcrop_unit_chk.sv
// Property checker for the horizontal crop unit, attached by bind.
module hcrop_unit_chk
    import hcrop_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_fire,
    input logic             keep,
    input logic             at_start,
    input logic             cfg_hold,
    input crop_cfg_t        active_cfg,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_data,
    input logic             out_eol,
    input logic             out_eof
);
    logic [FIELD_W-1:0] line_cnt;
    logic [FIELD_W-1:0] win_w;
    logic               out_fire;

    // Window width and output handshake seen by the checker.
    always_comb begin
        win_w    = active_cfg.w_m1 - active_cfg.right - active_cfg.left;
        out_fire = out_valid && out_ready;
    end

    // Output pixels counted since the last output end-of-line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_cnt <= '0;
        else if (out_fire)
            line_cnt <= out_eol ? '0 : line_cnt + 1'b1;
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_eol) && $stable(out_eof));

    // R10
    eof_with_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eof |-> out_eol);

    // R4
    drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && !keep |=> !out_valid);

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && at_start && cfg_hold |=> $stable(active_cfg));

    // R5
    line_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && out_eol && !active_cfg.bypass |-> line_cnt + 1'b1 == win_w);
endmodule

bind hcrop_unit hcrop_unit_chk #(.PIX_W(PIX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_fire    (in_fire),
    .keep       (keep),
    .at_start   (at_start),
    .cfg_hold   (cfg_hold),
    .active_cfg (active_cfg),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_eol    (out_eol),
    .out_eof    (out_eof)
);

// File: tb/hcrop_unit_bench.sv
module hcrop_unit_bench;
    localparam int PIX_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_bypass = 1'b0;
    logic             cfg_hold = 1'b0;
    logic [31:0]      cfg_size = '0;
    logic [31:0]      cfg_crop = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PIX_W-1:0] in_data = '0;
    logic             in_eol = 1'b0;
    logic             in_eof = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [PIX_W-1:0] out_data;
    logic             out_eol;
    logic             out_eof;

    int tests = 0;
    int fails = 0;
    bit bp_on = 1'b0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // Expected output entries: {eof, eol, data}
    logic [PIX_W+1:0] expq[$];

    // Reference model of the active configuration
    int m_byp = 1, m_w = 0, m_h = 0, m_l = 0, m_r = 0;

    // Stall tracking for the hold check
    bit               prev_stall = 1'b0;
    logic [PIX_W+1:0] prev_out;

    always #2 clk = ~clk;

    hcrop_unit #(.PIX_W(PIX_W)) u_hcrop_unit (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_hold(cfg_hold),
        .cfg_size(cfg_size), .cfg_crop(cfg_crop),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_eol(in_eol), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_eol(out_eol), .out_eof(out_eof)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Downstream ready pattern
    always @(negedge clk) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= bp_on ? lfsr[0] : 1'b1;
    end

    // Output monitor, compared against the model every clock
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (prev_stall) begin
                // R9: held output under backpressure
                check(out_valid && {out_eof, out_eol, out_data} == prev_out,
                      "R9", {7'd0, out_valid, out_eof, out_eol, out_data}, {8'd1, prev_out});
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R3 unexpected output", {6'd0, out_eof, out_eol, out_data}, 32'd0);
                end else begin
                    logic [PIX_W+1:0] e;
                    e = expq.pop_front();
                    // R2 R3 R5 R6: pixel order and regenerated markers
                    check({out_eof, out_eol, out_data} == e, "R2/R3/R5/R6 pixel",
                          {6'd0, out_eof, out_eol, out_data}, {6'd0, e});
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_out   = {out_eof, out_eol, out_data};
        end
    end

    task automatic send_pix(input logic [PIX_W-1:0] d, input logic e, input logic f);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_eol   = e;
        in_eof   = f;
        forever begin
            #2;
            // R4: with no backpressure, input is never stalled
            if (!bp_on) check(in_ready, "R4 ready", {31'd0, in_ready}, 32'd1);
            if (in_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic drive_frame(input int fid, input int chg_row, input logic [31:0] new_crop);
        int w, h, lim;
        w = int'(cfg_size[31:16]) + 1;
        h = int'(cfg_size[15:0]) + 1;
        if (!cfg_hold) begin
            m_byp = cfg_bypass;
            m_w = w; m_h = h;
            m_l = int'(cfg_crop[31:16]);
            m_r = int'(cfg_crop[15:0]);
        end
        lim = m_w - 1 - m_r;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                logic [PIX_W-1:0] d;
                d = {fid[7:0], r[7:0], c[7:0]};
                if (m_byp != 0)
                    expq.push_back({(r == h-1 && c == w-1), (c == w-1), d});
                else if (c >= m_l && c < lim)
                    expq.push_back({(r == m_h-1 && c == lim-1), (c == lim-1), d});
            end
        end
        for (int r = 0; r < h; r++) begin
            if (r == chg_row) cfg_crop = new_crop;
            for (int c = 0; c < w; c++)
                send_pix({fid[7:0], r[7:0], c[7:0]}, c == w-1, (r == h-1) && (c == w-1));
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eol = 1'b0;
        in_eof = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400 && (expq.size() != 0 || out_valid); i++) @(negedge clk);
        check(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(!out_valid && in_ready, "R1 reset", {30'd0, out_valid, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 after reset", {30'd0, out_valid, in_ready}, 32'd1);

        // R2: bypass, 8x3
        cfg_bypass = 1'b1; cfg_size = {16'd7, 16'd2}; cfg_crop = '0;
        drive_frame(1, -1, '0);
        drain("R2 bypass frame complete");

        // R3 R7 R9: left 2, right field 1 on 10x4 with backpressure
        bp_on = 1'b1;
        cfg_bypass = 1'b0; cfg_size = {16'd9, 16'd3}; cfg_crop = {16'd2, 16'd1};
        drive_frame(2, -1, '0);
        drain("R3 crop frame complete");

        // R3 R4: right field 0 still drops the last pixel, 6x2
        bp_on = 1'b0;
        cfg_size = {16'd5, 16'd1}; cfg_crop = {16'd0, 16'd0};
        drive_frame(3, -1, '0);
        drain("R3 zero right field frame complete");

        // R5 R6: single-pixel window on 8x3
        bp_on = 1'b1;
        cfg_size = {16'd7, 16'd2}; cfg_crop = {16'd3, 16'd3};
        drive_frame(4, -1, '0);
        drain("R6 single-pixel frame complete");

        // R7: change in mid-frame is ignored until the next frame
        bp_on = 1'b0;
        cfg_size = {16'd9, 16'd3}; cfg_crop = {16'd1, 16'd2};
        drive_frame(5, 2, {16'd4, 16'd0});
        drain("R7 mid-frame change ignored");
        drive_frame(6, -1, '0);
        drain("R7 change applied next frame");

        // R8: reload-hold keeps the previous window, release applies new one
        bp_on = 1'b1;
        cfg_hold = 1'b1; cfg_crop = {16'd0, 16'd5};
        drive_frame(7, -1, '0);
        drain("R8 held configuration");
        cfg_hold = 1'b0;
        drive_frame(8, -1, '0);
        drain("R8 released configuration");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule